// File: doc/BRIEF.md
# Multi-Register Zip/Unzip Unit

This block moves elements between a register file and itself in interleaved order. In zip mode it reads up to three source vectors and writes them, one unit from each source per round, into one contiguous destination vector. In unzip mode it reads one contiguous vector and scatters its units back to up to three destination vectors, using the same slot order. A unit is one register, or a group of two to four consecutive registers that is moved as a whole when the group size is above one.

A 32-bit instruction word carries the mode, the packed-vector base and up to three per-slot bases. Zero base fields lower the number of slots. The vector length, the group size, the source and destination element widths and the saturation mode come in as side inputs. All of these are captured on the start cycle. Every element passes through a width converter on its way. The converter zero-extends or truncates by default. It can instead clamp to the destination range, treating the value as unsigned or as signed.

The unit drives one combinational read port and one write port on the register file, and moves one element per busy cycle. A one-cycle done pulse closes each operation.

Top module: `zip_unzip_unit`

## Requirements
- R1: `start_i` is taken at a rising edge of `clk_i` only when `busy_o` is low, which includes the cycle in which `done_o` is high. A legal operation with a nonzero length raises `busy_o` from the next cycle. A `start_i` seen while `busy_o` is high is ignored and leaves the running operation unchanged.
- R2: An instruction is legal when bits [5:0] equal 19 and bits [30:26] equal 12 (zip) or 13 (unzip). Any other word raises `done_o` in the next cycle and writes nothing. Bit 31 has no effect.
- R3: The slot fields are B = bits [20:16], C = bits [15:11] and A = bits [25:21]. The packed base P is bits [10:6]. If B is 0 there is one slot, C, and A is ignored. If B is nonzero and A is 0, the slots are B then C. Otherwise the slots are B, C, A in that order.
- R4: In zip mode with n slots and group size g, packed unit i·n+s is read from slot s unit i. Packed unit k occupies registers P+k·g .. P+k·g+g−1.
- R5: In unzip mode the mapping of R4 is inverted: packed unit i·n+s is read and written to slot s unit i.
- R6: Slot unit i occupies registers base+i·g .. base+i·g+g−1. The group size g is `subvl_i`+1, from 1 to 4. A group is moved as one unit.
- R7: One element moves per busy cycle. The order is group member innermost, then slot, then unit index. There are exactly `vl_i`·n·g busy cycles. The read data is used in the same cycle it is addressed, and `done_o` is high for the single cycle after the last write.
- R8: Width codes 0..3 select 8, 16, 32 or 64 bits. With `sat_mode_i` at 0 or 3, the low source-width bits of the read value are zero-extended or truncated to the destination width. Bits above the destination width are always written as 0.
- R9: With `sat_mode_i` = 1, the source field is read as unsigned and clamped to 2^dw−1. An 8-bit destination therefore saturates at 255.
- R10: With `sat_mode_i` = 2, the source field is read as signed and clamped to [−2^(dw−1), 2^(dw−1)−1], for example 127 and −128 at 8 bits. The result is stored as a dw-bit two's-complement field.
- R11: All register addresses wrap modulo 2^RF_AW.
- R12: A legal instruction with `vl_i` = 0 raises `done_o` in the next cycle and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request |
| instr_i | input | 32 | Instruction word |
| vl_i | input | VL_W | Units per slot |
| subvl_i | input | 2 | Group size minus one |
| src_ew_i | input | 2 | Source element width code |
| dst_ew_i | input | 2 | Destination element width code |
| sat_mode_i | input | 2 | 0/3 plain, 1 unsigned clamp, 2 signed clamp |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_raddr_o | output | RF_AW | Register-file read address |
| rf_rdata_i | input | XLEN | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | RF_AW | Register-file write address |
| rf_wdata_o | output | XLEN | Register-file write data |

## Verification
Two events can share a cycle here. The first is the done pulse of one operation together with the start of the next. The second is a read and a write to the same register when the packed area overlaps a slot area. The bench provokes the first by raising `start_i` in the done cycle. It then expects `busy_o` in the very next cycle and the second operation's full address and data sequence. The second is provoked by overlapping and wrapping bases, and the bench judges it against a sequential model in which each read sees every earlier write of the same operation.

// File: rtl/zu_pkg.sv
package zu_pkg;
  localparam logic [5:0] OPC_MAJOR = 6'd19;
  localparam logic [4:0] XO_ZIP    = 5'd12;
  localparam logic [4:0] XO_UNZIP  = 5'd13;

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_UNS  = 2'd1,
    SAT_SGN  = 2'd2,
    SAT_RSVD = 2'd3
  } sat_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } state_e;

  typedef struct packed {
    logic            legal;
    logic            unzip;
    logic [1:0]      nsrc;
    logic [4:0]      rt;
    logic [2:0][4:0] base;
  } op_t;
endpackage

// File: rtl/zu_decode.sv
module zu_decode
  import zu_pkg::*;
(
  input  logic [31:0] instr_i,
  output op_t         op_o
);
  logic [5:0] f_opc;
  logic [4:0] f_rt, f_rc, f_rb, f_ra, f_xo;
  logic       unused_flag;

  assign f_opc       = instr_i[5:0];
  assign f_rt        = instr_i[10:6];
  assign f_rc        = instr_i[15:11];
  assign f_rb        = instr_i[20:16];
  assign f_ra        = instr_i[25:21];
  assign f_xo        = instr_i[30:26];
  assign unused_flag = instr_i[31];

  always_comb begin
    op_o       = '0;
    op_o.rt    = f_rt;
    op_o.unzip = (f_xo == XO_UNZIP);
    op_o.legal = (f_opc == OPC_MAJOR) && ((f_xo == XO_ZIP) || (f_xo == XO_UNZIP));
    if (f_rb == 5'd0) begin
      // single slot: only C is used
      op_o.nsrc    = 2'd1;
      op_o.base[0] = f_rc;
    end else begin
      op_o.base[0] = f_rb;
      op_o.base[1] = f_rc;
      op_o.base[2] = f_ra;
      op_o.nsrc    = (f_ra == 5'd0) ? 2'd2 : 2'd3;
    end
  end
endmodule

// File: rtl/zu_seq.sv
module zu_seq
  import zu_pkg::*;
#(
  parameter int RF_AW = 7,
  parameter int VL_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  op_t              op_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [1:0]       subvl_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             unzip_o,
  output logic [RF_AW-1:0] rd_addr_o,
  output logic [RF_AW-1:0] wr_addr_o
);
  typedef logic [RF_AW-1:0] addr_t;
  typedef logic [VL_W-1:0]  vl_t;

  state_e     st_q, st_d;
  op_t        op_q;
  vl_t        vl_q, i_q;
  logic [1:0] sub_q, s_q, j_q;
  addr_t      pack_q, row_q, slot_a;
  logic       go, j_wrap, s_wrap, last;

  assign accept_o = start_i && (st_q != ST_BUSY);
  assign go       = accept_o && op_i.legal && (vl_i != '0);
  assign j_wrap   = (j_q == sub_q);
  assign s_wrap   = (s_q == op_q.nsrc - 2'd1);
  assign last     = j_wrap && s_wrap && (i_q == vl_q - vl_t'(1));
  assign slot_a   = addr_t'(op_q.base[s_q]) + row_q + addr_t'(j_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_BUSY: if (last) st_d = ST_DONE;
      default: begin
        if (accept_o)         st_d = go ? ST_BUSY : ST_DONE;
        else if (st_q != ST_IDLE) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      vl_q   <= '0;
      sub_q  <= '0;
      i_q    <= '0;
      s_q    <= '0;
      j_q    <= '0;
      pack_q <= '0;
      row_q  <= '0;
    end else begin
      st_q <= st_d;
      if (go) begin
        op_q   <= op_i;
        vl_q   <= vl_i;
        sub_q  <= subvl_i;
        i_q    <= '0;
        s_q    <= '0;
        j_q    <= '0;
        pack_q <= addr_t'(op_i.rt);
        row_q  <= '0;
      end else if (st_q == ST_BUSY) begin
        pack_q <= pack_q + addr_t'(1);
        if (j_wrap) begin
          j_q <= '0;
          if (s_wrap) begin
            s_q   <= '0;
            i_q   <= i_q + vl_t'(1);
            row_q <= row_q + addr_t'(sub_q) + addr_t'(1);
          end else begin
            s_q <= s_q + 2'd1;
          end
        end else begin
          j_q <= j_q + 2'd1;
        end
      end
    end
  end

  assign busy_o    = (st_q == ST_BUSY);
  assign done_o    = (st_q == ST_DONE);
  assign unzip_o   = op_q.unzip;
  assign rd_addr_o = op_q.unzip ? pack_q : slot_a;
  assign wr_addr_o = op_q.unzip ? slot_a : pack_q;
endmodule

// File: rtl/zu_conv.sv
module zu_conv
  import zu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] din_i,
  input  logic [1:0]      sew_i,
  input  logic [1:0]      dew_i,
  input  logic [1:0]      sat_i,
  output logic [XLEN-1:0] dout_o
);
  localparam int W = XLEN + 2;
  typedef logic signed [W-1:0] wide_t;

  int            sw, dw;
  logic [XLEN-1:0] smask, dmask, raw;
  wide_t         uval, sval, res, umax, smax, smin;

  always_comb begin
    sw = 8 << sew_i;
    if (sw > XLEN) sw = XLEN;
    dw = 8 << dew_i;
    if (dw > XLEN) dw = XLEN;
    smask = (sw >= XLEN) ? '1 : ((XLEN'(1) << sw) - XLEN'(1));
    dmask = (dw >= XLEN) ? '1 : ((XLEN'(1) << dw) - XLEN'(1));
    raw   = din_i & smask;
    uval  = wide_t'({2'b00, raw});
    sval  = raw[sw-1] ? (uval - (wide_t'(1) << sw)) : uval;
    umax  = (wide_t'(1) << dw) - wide_t'(1);
    smax  = (wide_t'(1) << (dw - 1)) - wide_t'(1);
    smin  = -(wide_t'(1) << (dw - 1));
    case (sat_e'(sat_i))
      SAT_UNS: res = (uval > umax) ? umax : uval;
      SAT_SGN: res = (sval > smax) ? smax : ((sval < smin) ? smin : sval);
      default: res = uval;
    endcase
    dout_o = res[XLEN-1:0] & dmask;
  end
endmodule

// File: rtl/zip_unzip_unit.sv
module zip_unzip_unit
  import zu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int RF_AW = 7,
  parameter int VL_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      instr_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [1:0]       subvl_i,
  input  logic [1:0]       src_ew_i,
  input  logic [1:0]       dst_ew_i,
  input  logic [1:0]       sat_mode_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RF_AW-1:0] rf_raddr_o,
  input  logic [XLEN-1:0]  rf_rdata_i,
  output logic             rf_we_o,
  output logic [RF_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]  rf_wdata_o
);
  op_t        dec_op;
  logic       accept;
  logic       unzip_mode;
  logic [1:0] sew_q, dew_q, sat_q;

  zu_decode u_decode (
    .instr_i (instr_i),
    .op_o    (dec_op)
  );

  zu_seq #(.RF_AW(RF_AW), .VL_W(VL_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .op_i      (dec_op),
    .vl_i      (vl_i),
    .subvl_i   (subvl_i),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .unzip_o   (unzip_mode),
    .rd_addr_o (rf_raddr_o),
    .wr_addr_o (rf_waddr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sew_q <= '0;
      dew_q <= '0;
      sat_q <= '0;
    end else if (accept) begin
      sew_q <= src_ew_i;
      dew_q <= dst_ew_i;
      sat_q <= sat_mode_i;
    end
  end

  zu_conv #(.XLEN(XLEN)) u_conv (
    .din_i  (rf_rdata_i),
    .sew_i  (sew_q),
    .dew_i  (dew_q),
    .sat_i  (sat_q),
    .dout_o (rf_wdata_o)
  );

  assign rf_we_o = busy_o;
endmodule

// File: rtl/zu_checker.sv
module zu_checker #(
  parameter int XLEN  = 64,
  parameter int RF_AW = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             rf_we_o,
  input logic [RF_AW-1:0] rf_raddr_o,
  input logic [RF_AW-1:0] rf_waddr_o,
  input logic [XLEN-1:0]  rf_wdata_o,
  input logic             unzip_mode,
  input logic [1:0]       dew_q
);
  AST_BUSY_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)) else $error("busy without start"); // R1

  AST_ZIP_DEST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !unzip_mode) |-> (rf_waddr_o == $past(rf_waddr_o) + 1'b1))
    else $error("zip destination not sequential"); // R4

  AST_UNZIP_SRC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && unzip_mode) |-> (rf_raddr_o == $past(rf_raddr_o) + 1'b1))
    else $error("unzip source not sequential"); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> ((rf_wdata_o >> (8 << dew_q)) == '0)) else $error("bits above width"); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o) else $error("no done after transfers"); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rf_we_o) else $error("write during done"); // R12
endmodule

bind zip_unzip_unit zu_checker #(.XLEN(XLEN), .RF_AW(RF_AW)) u_zu_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rf_we_o    (rf_we_o),
  .rf_raddr_o (rf_raddr_o),
  .rf_waddr_o (rf_waddr_o),
  .rf_wdata_o (rf_wdata_o),
  .unzip_mode (unzip_mode),
  .dew_q      (dew_q)
);

// File: tb/zip_unzip_unit_bench.sv
module zip_unzip_unit_bench;
  localparam int XLEN  = 64;
  localparam int RF_AW = 7;
  localparam int VL_W  = 4;
  localparam int NREG  = 1 << RF_AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             start;
  logic [31:0]      instr;
  logic [VL_W-1:0]  vl;
  logic [1:0]       subvl, sew, dew, satm;
  logic             busy, done, we;
  logic [RF_AW-1:0] raddr, waddr;
  logic [XLEN-1:0]  rdata, wdata;

  zip_unzip_unit #(.XLEN(XLEN), .RF_AW(RF_AW), .VL_W(VL_W)) u_zip_unzip_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr), .vl_i(vl),
    .subvl_i(subvl), .src_ew_i(sew), .dst_ew_i(dew), .sat_mode_i(satm),
    .busy_o(busy), .done_o(done), .rf_raddr_o(raddr), .rf_rdata_i(rdata),
    .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata)
  );

  function automatic logic [63:0] pat(int k);
    return (64'h9E3779B97F4A7C15 * 64'(k + 1)) ^ 64'(k << 3);
  endfunction

  logic [63:0] rf [NREG];
  logic [63:0] model_rf [NREG];
  assign rdata = rf[raddr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) rf[k] <= pat(k);
    end else if (we) begin
      rf[waddr] <= wdata;
    end
  end

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int opc, int rt, int rc, int rb, int ra, int xo, int flag);
    return {1'(flag), 5'(xo), 5'(ra), 5'(rb), 5'(rc), 5'(rt), 6'(opc)};
  endfunction

  // behavioural width conversion
  function automatic logic [63:0] ref_conv(logic [63:0] v, int sw, int dw, int mode);
    logic signed [127:0] x, hi, lo;
    logic [63:0] raw;
    raw = (sw == 64) ? v : (v % (64'd1 << sw));
    x = $signed({64'd0, raw});
    if (mode == 2 && raw[sw-1]) x = x - (128'sd1 <<< sw);
    if (mode == 1) begin
      hi = (128'sd1 <<< dw) - 1;
      if (x > hi) x = hi;
    end else if (mode == 2) begin
      hi = (128'sd1 <<< (dw - 1)) - 1;
      lo = -(128'sd1 <<< (dw - 1));
      if (x > hi) x = hi;
      if (x < lo) x = lo;
    end
    return (dw == 64) ? x[63:0] : (x[63:0] % (64'd1 << dw));
  endfunction

  int q_rd[$];
  int q_wr[$];
  int cur_sw, cur_dw, cur_mode;

  task automatic begin_op(logic [31:0] iw, int n_vl, int g, int s_code, int d_code, int mode);
    int opc, xo, rt, rc, rb, ra, n;
    int slot [3];
    instr = iw; vl = VL_W'(n_vl); subvl = 2'(g - 1);
    sew = 2'(s_code); dew = 2'(d_code); satm = 2'(mode);
    start = 1'b1;
    opc = int'(iw[5:0]); rt = int'(iw[10:6]); rc = int'(iw[15:11]);
    rb = int'(iw[20:16]); ra = int'(iw[25:21]); xo = int'(iw[30:26]);
    cur_sw = 8 << s_code; cur_dw = 8 << d_code; cur_mode = mode;
    q_rd.delete(); q_wr.delete();
    if (opc != 19 || (xo != 12 && xo != 13)) return;
    if (rb == 0) begin n = 1; slot[0] = rc; end
    else begin slot[0] = rb; slot[1] = rc; slot[2] = ra; n = (ra == 0) ? 2 : 3; end
    for (int i = 0; i < n_vl; i++)
      for (int s = 0; s < n; s++)
        for (int j = 0; j < g; j++) begin
          int pk, sl;
          pk = (rt + (i * n + s) * g + j) % NREG;
          sl = (slot[s] + i * g + j) % NREG;
          if (xo == 12) begin q_rd.push_back(sl); q_wr.push_back(pk); end
          else          begin q_rd.push_back(pk); q_wr.push_back(sl); end
        end
  endtask

  task automatic finish_op(string req, int poke_at);
    int cyc = 0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (q_rd.size() > 0) begin
        logic [63:0] exp_d;
        exp_d = ref_conv(model_rf[q_rd[0]], cur_sw, cur_dw, cur_mode);
        check(busy && we && !done, req, "busy/we", {61'd0, busy, we, done}, 64'd6);
        check(raddr == RF_AW'(q_rd[0]) && waddr == RF_AW'(q_wr[0]), req, "raddr/waddr",
              {50'd0, raddr, waddr}, {50'd0, RF_AW'(q_rd[0]), RF_AW'(q_wr[0])});
        check(wdata == exp_d, req, "wdata", wdata, exp_d);
        model_rf[q_wr[0]] = exp_d;
        void'(q_rd.pop_front()); void'(q_wr.pop_front());
        if (cyc == poke_at) begin
          start = 1'b1;
          instr = mk(19, 3, 4, 5, 6, 13, 0);
          vl = VL_W'(7);
        end
        cyc++;
      end else begin
        check(done && !busy && !we, req, "done pulse", {61'd0, busy, we, done}, 64'd1);
        break;
      end
    end
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    check(!done && !busy && !we, req, "idle after done", {61'd0, busy, we, done}, 64'd0);
  endtask

  task automatic op(logic [31:0] iw, int n_vl, int g, int s_code, int d_code, int mode, string req);
    begin_op(iw, n_vl, g, s_code, d_code, mode);
    finish_op(req, -1);
    idle_check(req);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) model_rf[k] = pat(k);
    rst_n = 1'b0; start = 1'b0; instr = '0; vl = '0; subvl = '0;
    sew = '0; dew = '0; satm = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !we, "R1", "reset outputs", {61'd0, busy, we, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", {62'd0, busy, done}, 64'd0);

    // R3 single slot, A field ignored; R4 copy
    op(mk(19, 9, 3, 0, 7, 12, 0), 4, 1, 3, 3, 0, "R3");
    // R4 two slots, bit 31 set (R2)
    op(mk(19, 20, 6, 2, 0, 12, 1), 5, 1, 3, 3, 0, "R4");
    // R6 three slots, groups of two
    op(mk(19, 1, 28, 25, 31, 12, 0), 3, 2, 3, 3, 0, "R6");
    // R5 unzip three slots, groups of three
    op(mk(19, 2, 17, 30, 11, 13, 0), 2, 3, 3, 3, 0, "R5");
    // R5 unzip two slots
    op(mk(19, 22, 14, 5, 0, 13, 0), 4, 1, 3, 3, 0, "R5");
    // R8 truncation and widening
    op(mk(19, 12, 4, 0, 0, 12, 0), 6, 1, 3, 0, 0, "R8");
    op(mk(19, 24, 12, 0, 0, 12, 0), 6, 1, 0, 2, 0, "R8");
    // R9 unsigned clamp
    op(mk(19, 8, 0, 26, 0, 12, 0), 4, 1, 3, 0, 1, "R9");
    op(mk(19, 3, 12, 0, 0, 12, 0), 6, 1, 1, 0, 1, "R9");
    // R10 signed clamp and signed widening
    op(mk(19, 5, 1, 9, 19, 12, 0), 3, 1, 3, 0, 2, "R10");
    op(mk(19, 16, 12, 0, 0, 12, 0), 6, 1, 1, 0, 2, "R10");
    op(mk(19, 27, 12, 0, 0, 13, 0), 6, 1, 0, 2, 2, "R10");
    // R2 illegal opcode and illegal sub-opcode; R12 zero length
    op(mk(18, 4, 5, 6, 7, 12, 0), 3, 1, 3, 3, 0, "R2");
    op(mk(19, 4, 5, 6, 7, 14, 0), 3, 1, 3, 3, 0, "R2");
    op(mk(19, 4, 5, 6, 7, 12, 0), 0, 1, 3, 3, 0, "R12");
    // R11 wrap, with R1 start poked while busy
    begin_op(mk(19, 31, 9, 3, 29, 12, 0), 15, 4, 3, 3, 0);
    finish_op("R11", 10);
    idle_check("R11");
    // R1/R7 start in the done cycle
    begin_op(mk(19, 10, 20, 6, 0, 13, 0), 3, 2, 2, 1, 2);
    finish_op("R7", -1);
    begin_op(mk(19, 0, 7, 21, 15, 12, 0), 2, 1, 3, 3, 0);
    finish_op("R1", -1);
    idle_check("R7");

    begin
      bit same = 1;
      for (int k = 0; k < NREG; k++) if (rf[k] !== model_rf[k]) same = 0;
      check(same, "R4", "register file contents", 64'(same), 64'd1);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule